// File: doc/BRIEF.md
# Bridge Downstream Forwarding Decoder

This block makes the claim decision for a PCI-to-PCI style bridge. For every memory or I/O request seen on either side of the bridge, it decides whether the request must be claimed and passed across. A request from the primary side may be sent downstream. A request from the secondary side may be sent upstream. The decision draws on four control bits held in a small write port, a 64-bit request address, and an I/O base/limit window supplied as inputs.

Two legacy behaviours shape the decoder. The first is a display pass-through mode. When it is on, the classic display memory hole and the two display I/O ranges go downstream whatever the I/O window says. The I/O ranges repeat every 1 KB of the low 64 KB. The second is a legacy-card mode. It cuts a hole into the I/O window by refusing every address whose offset inside its 1 KB block is 100h or above. When pass-through is off, the display memory hole is handed upstream instead. Every decision appears on registered outputs one clock after the request strobe.

Top module: `bridge_fwd_decoder`

## Requirements
- R1: After reset all four control bits are zero, so no request is claimed in either direction, and `fwdValid`, `claimDown` and `claimUp` are low until a request arrives.
- R2: `fwdValid` is high in exactly the cycle after a cycle with `reqValid` high. `claimDown` and `claimUp` are low whenever `fwdValid` is low.
- R3: A primary-side memory request (`reqIsIo`=0, `reqFromSec`=0) gives `claimDown`=1 exactly when pass-through (bit 3) and memory space enable (bit 1) are set and the address lies in 000A0000h..000BFFFFh.
- R4: A primary-side I/O request goes downstream when pass-through and I/O space enable (bit 0) are set, address bits [63:16] are zero, and address bits [9:0] are in 3B0h..3BBh or 3C0h..3DFh. Bits [15:10] are ignored, so 7B0h and 13C0h also hit. This holds regardless of the I/O window.
- R5: A primary-side I/O request with I/O space enable set and `ioBase` <= address <= `ioLimit` (both zero-extended) goes downstream unless R6 blocks it.
- R6: With the legacy-card bit (bit 2) set, a windowed primary I/O request with address bits [63:16] zero and bits [9:8] non-zero is not sent down. The bit has no effect above 64 KB or outside the window, and R4 takes priority over it.
- R7: A secondary-side memory request gives `claimUp`=1 exactly when pass-through is clear, memory space enable is set, and the address lies in 000A0000h..000BFFFFh.
- R8: A secondary-side I/O request gives `claimUp`=1 exactly when I/O space enable is set and the same address would not be sent downstream under R4 to R6.
- R9: A cycle with `cfgWrEn` high loads `cfgWrData` into the control bits (bit 0 I/O space enable, bit 1 memory space enable, bit 2 legacy-card holes, bit 3 pass-through). The new values apply from the next request. With `cfgWrEn` low, `cfgWrData` has no effect.
- R10: `claimDown` and `claimUp` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control write strobe |
| cfgWrData | input | 4 | Control bits: [0] I/O space, [1] memory space, [2] legacy-card holes, [3] pass-through |
| ioBase | input | 32 | Lowest address of the I/O window |
| ioLimit | input | 32 | Highest address of the I/O window |
| reqValid | input | 1 | Request present this cycle |
| reqIsIo | input | 1 | 1 = I/O request, 0 = memory request |
| reqFromSec | input | 1 | 1 = request seen on the secondary side |
| reqAddr | input | 64 | Request address |
| fwdValid | output | 1 | A decision is presented this cycle |
| claimDown | output | 1 | Claim and forward primary to secondary |
| claimUp | output | 1 | Claim and forward secondary to primary |

## Verification
Every decision is due exactly one rising edge after the cycle that carries its request. A control write takes effect for requests that are presented from the next edge onward. The bench drives each request on a falling edge and lets one rising edge pass. It then compares all three outputs a fraction of a cycle later with a behavioural model that uses integer offsets and comparisons. Idle cycles are checked the same way, to confirm that nothing is claimed without a request.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Bits below this position form the legacy 64 KB I/O space.
  localparam int LEGACY_BITS = 16;
  // I/O ranges repeat every 2**ALIAS_BITS bytes.
  localparam int ALIAS_BITS  = 10;

  localparam logic [63:0] VGA_MEM_LO = 64'h0000_0000_000A_0000;
  localparam logic [63:0] VGA_MEM_HI = 64'h0000_0000_000B_FFFF;

  localparam logic [ALIAS_BITS-1:0] VGA_IO_A_LO = 10'h3B0;
  localparam logic [ALIAS_BITS-1:0] VGA_IO_A_HI = 10'h3BB;
  localparam logic [ALIAS_BITS-1:0] VGA_IO_B_LO = 10'h3C0;
  localparam logic [ALIAS_BITS-1:0] VGA_IO_B_HI = 10'h3DF;
  localparam logic [ALIAS_BITS-1:0] ISA_HOLE_LO = 10'h100;

  // Software-visible control bits, in write-data bit order (msb first).
  typedef struct packed {
    logic vgaPassEn;   // bit 3
    logic isaHoleEn;   // bit 2
    logic memSpaceEn;  // bit 1
    logic ioSpaceEn;   // bit 0
  } ctrl_bits_t;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic loadDecision;
    logic clearDecision;
  } dp_strobe_t;

endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrEn,
  input  logic [3:0] cfgWrData,
  input  logic       reqValid,
  output ctrl_bits_t ctrlBits,
  output dp_strobe_t strobe,
  output logic       fwdValid
);

  ctrl_bits_t ctrlQ;
  logic       validQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlQ  <= '0;
      validQ <= 1'b0;
    end else begin
      if (cfgWrEn) ctrlQ <= ctrl_bits_t'(cfgWrData);
      validQ <= reqValid;
    end
  end

  always_comb begin
    strobe.loadDecision  = reqValid;
    strobe.clearDecision = !reqValid && validQ;
  end

  assign ctrlBits = ctrlQ;
  assign fwdValid = validQ;

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IO_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        strobe,
  input  ctrl_bits_t        ctrlBits,
  input  logic              reqIsIo,
  input  logic              reqFromSec,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [IO_W-1:0]   ioBase,
  input  logic [IO_W-1:0]   ioLimit,
  output logic              claimDown,
  output logic              claimUp
);

  localparam int HIGH_W = ADDR_W - LEGACY_BITS;

  logic                  highZero;
  logic [ALIAS_BITS-1:0] aliasOff;
  logic                  vgaIoHit, vgaMemHit, windowHit, isaHole;
  logic                  downIo, downMem, upIo, upMem;
  logic                  nextDown, nextUp;
  logic [ADDR_W-1:0]     baseExt, limitExt;

  assign baseExt  = ADDR_W'(ioBase);
  assign limitExt = ADDR_W'(ioLimit);

  always_comb begin
    highZero  = (reqAddr[ADDR_W-1:LEGACY_BITS] == HIGH_W'(0));
    aliasOff  = reqAddr[ALIAS_BITS-1:0];
    vgaIoHit  = highZero &&
                (((aliasOff >= VGA_IO_A_LO) && (aliasOff <= VGA_IO_A_HI)) ||
                 ((aliasOff >= VGA_IO_B_LO) && (aliasOff <= VGA_IO_B_HI)));
    vgaMemHit = (reqAddr >= ADDR_W'(VGA_MEM_LO)) && (reqAddr <= ADDR_W'(VGA_MEM_HI));
    windowHit = (reqAddr >= baseExt) && (reqAddr <= limitExt);
    isaHole   = ctrlBits.isaHoleEn && highZero && (aliasOff >= ISA_HOLE_LO);

    downIo  = ctrlBits.ioSpaceEn &&
              ((ctrlBits.vgaPassEn && vgaIoHit) || (windowHit && !isaHole));
    downMem = ctrlBits.memSpaceEn && ctrlBits.vgaPassEn && vgaMemHit;
    upIo    = ctrlBits.ioSpaceEn && !downIo;
    upMem   = ctrlBits.memSpaceEn && !ctrlBits.vgaPassEn && vgaMemHit;

    nextDown = !reqFromSec && (reqIsIo ? downIo : downMem);
    nextUp   =  reqFromSec && (reqIsIo ? upIo   : upMem);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claimDown <= 1'b0;
      claimUp   <= 1'b0;
    end else if (strobe.loadDecision) begin
      claimDown <= nextDown;
      claimUp   <= nextUp;
    end else if (strobe.clearDecision) begin
      claimDown <= 1'b0;
      claimUp   <= 1'b0;
    end
  end

endmodule

// File: rtl/bridge_fwd_decoder.sv
module bridge_fwd_decoder
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IO_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [3:0]        cfgWrData,
  input  logic [IO_W-1:0]   ioBase,
  input  logic [IO_W-1:0]   ioLimit,
  input  logic              reqValid,
  input  logic              reqIsIo,
  input  logic              reqFromSec,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              fwdValid,
  output logic              claimDown,
  output logic              claimUp
);

  ctrl_bits_t ctrlBits;
  dp_strobe_t strobe;

  fwd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .reqValid  (reqValid),
    .ctrlBits  (ctrlBits),
    .strobe    (strobe),
    .fwdValid  (fwdValid)
  );

  fwd_datapath #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .ctrlBits   (ctrlBits),
    .reqIsIo    (reqIsIo),
    .reqFromSec (reqFromSec),
    .reqAddr    (reqAddr),
    .ioBase     (ioBase),
    .ioLimit    (ioLimit),
    .claimDown  (claimDown),
    .claimUp    (claimUp)
  );

endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
  parameter int ADDR_W = 64,
  parameter int IO_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfgWrEn,
  input logic [3:0]        cfgWrData,
  input logic [IO_W-1:0]   ioBase,
  input logic [IO_W-1:0]   ioLimit,
  input logic              reqValid,
  input logic              reqIsIo,
  input logic              reqFromSec,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              fwdValid,
  input logic              claimDown,
  input logic              claimUp
);

  // R2: decision strobe follows the request strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> fwdValid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !fwdValid);
  a_r2_claim_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (claimDown || claimUp) |-> fwdValid);

  // R10: one direction at most
  a_r10_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(claimDown && claimUp));

  // R3: primary memory outside the display hole never goes down
  a_r3_mem_outside_hole: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqIsIo && !reqFromSec &&
     ((reqAddr < 64'h000A_0000) || (reqAddr > 64'h000B_FFFF))) |=> !claimDown);

  // R7: secondary memory outside the display hole never goes up
  a_r7_mem_outside_hole: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqIsIo && reqFromSec &&
     ((reqAddr < 64'h000A_0000) || (reqAddr > 64'h000B_FFFF))) |=> !claimUp);

  // R6: above 64 KB and above the window, primary I/O never goes down
  a_r6_high_io_not_down: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqIsIo && !reqFromSec && (reqAddr[ADDR_W-1:16] != '0) &&
     (reqAddr > ADDR_W'(ioLimit))) |=> !claimDown);

endmodule

bind bridge_fwd_decoder fwd_checker #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_chk (.*);

// File: tb/sim_bridge_fwd_decoder.sv
`timescale 1ns/100ps
module sim_bridge_fwd_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgWrData = '0;
  logic [31:0] ioBase = '0;
  logic [31:0] ioLimit = '0;
  logic        reqValid = 1'b0;
  logic        reqIsIo = 1'b0;
  logic        reqFromSec = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        fwdValid, claimDown, claimUp;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // bench's own copy of the control bits, updated by its own writes
  bit mIo = 0, mMem = 0, mIsa = 0, mVga = 0;

  always #2.5 clk = ~clk;

  bridge_fwd_decoder u0 (.*);

  function automatic bit inVgaMem(logic [63:0] a);
    return (a >= 64'd655360) && (a <= 64'd786431);
  endfunction

  function automatic bit inVgaIo(logic [63:0] a);
    int off;
    if (a >= 64'd65536) return 0;
    off = int'(a % 64'd1024);
    return (off >= 944 && off <= 955) || (off >= 960 && off <= 991);
  endfunction

  function automatic bit modelDownIo(logic [63:0] a);
    bit inWin, hole;
    if (!mIo) return 0;
    if (mVga && inVgaIo(a)) return 1;
    inWin = (a >= {32'd0, ioBase}) && (a <= {32'd0, ioLimit});
    hole  = mIsa && (a < 64'd65536) && ((a % 64'd1024) >= 64'd256);
    return inWin && !hole;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic writeCfg(logic [3:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = ~d;  // R9: garbage on data with enable low
    {mVga, mIsa, mMem, mIo} = {d[3], d[2], d[1], d[0]};
  endtask

  task automatic req(string tag, bit fromSec, bit isIo, logic [63:0] a);
    bit expDown, expUp;
    @(negedge clk);
    reqValid = 1'b1; reqFromSec = fromSec; reqIsIo = isIo; reqAddr = a;
    if (!fromSec) begin
      expDown = isIo ? modelDownIo(a) : (mVga && mMem && inVgaMem(a));
      expUp   = 0;
    end else begin
      expDown = 0;
      expUp   = isIo ? (mIo && !modelDownIo(a)) : (!mVga && mMem && inVgaMem(a));
    end
    @(posedge clk); #1;
    check(tag, "fwdValid", fwdValid, 1'b1);
    check(tag, "claimDown", claimDown, expDown);
    check(tag, "claimUp", claimUp, expUp);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk); #1;
    check(tag, "fwdValid idle", fwdValid, 1'b0);
    check(tag, "claimDown idle", claimDown, 1'b0);
    check(tag, "claimUp idle", claimUp, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    check("R1", "fwdValid", fwdValid, 1'b0);
    check("R1", "claimDown", claimDown, 1'b0);
    check("R1", "claimUp", claimUp, 1'b0);
    ioBase = 32'h0; ioLimit = 32'hFFFF;
    req("R1", 0, 0, 64'hA0000);
    req("R1", 0, 1, 64'h3C0);
    req("R1", 1, 1, 64'h3C0);
    idle("R2");

    // R9: write I/O + memory + pass-through (1011b)
    writeCfg(4'hB);
    ioBase = 32'h1000; ioLimit = 32'h1FFF;
    // R3: display memory hole downstream
    req("R3", 0, 0, 64'hA0000);
    req("R3", 0, 0, 64'hBFFFF);
    req("R3", 0, 0, 64'h9FFFF);
    req("R3", 0, 0, 64'hC0000);
    req("R3", 0, 0, 64'h1_000A_0000);
    req("R7", 1, 0, 64'hA0000);
    idle("R2");
    // R4: display I/O ranges with aliasing
    req("R4", 0, 1, 64'h3B0);
    req("R4", 0, 1, 64'h3BB);
    req("R4", 0, 1, 64'h3BC);
    req("R4", 0, 1, 64'h3AF);
    req("R4", 0, 1, 64'h3C0);
    req("R4", 0, 1, 64'h3DF);
    req("R4", 0, 1, 64'h3E0);
    req("R4", 0, 1, 64'h7B0);
    req("R4", 0, 1, 64'hFFDF);
    req("R4", 0, 1, 64'h1_0000_03B0);
    req("R4", 0, 1, 64'h103C0);
    // R5: window boundaries
    req("R5", 0, 1, 64'h1000);
    req("R5", 0, 1, 64'h1FFF);
    req("R5", 0, 1, 64'h0FFF);
    req("R5", 0, 1, 64'h2000);
    // R8: secondary I/O is the complement
    req("R8", 1, 1, 64'h1800);
    req("R8", 1, 1, 64'h3BC);
    req("R8", 1, 1, 64'h7B0);
    req("R8", 1, 1, 64'h1_0000_03B0);

    // R6: legacy-card holes (1111b), window covering 64 KB
    writeCfg(4'hF);
    ioBase = 32'h0; ioLimit = 32'hFFFF;
    req("R6", 0, 1, 64'h1000);
    req("R6", 0, 1, 64'h10FF);
    req("R6", 0, 1, 64'h1100);
    req("R6", 0, 1, 64'h13FF);
    req("R6", 0, 1, 64'h1400);
    req("R6", 0, 1, 64'h13C0);
    req("R6", 0, 1, 64'h17B5);
    req("R8", 1, 1, 64'h1100);
    ioLimit = 32'h2FFFF;
    req("R6", 0, 1, 64'h10100);
    req("R6", 0, 1, 64'h2FF00);
    ioBase = 32'h1000; ioLimit = 32'h1FFF;
    req("R6", 0, 1, 64'h2100);
    req("R6", 0, 1, 64'h1200);

    // R7: pass-through clear (0011b)
    writeCfg(4'h3);
    ioBase = 32'h1000; ioLimit = 32'h1FFF;
    req("R7", 1, 0, 64'hA0000);
    req("R7", 1, 0, 64'hBFFFF);
    req("R7", 1, 0, 64'hC0000);
    req("R7", 0, 0, 64'hA0000);
    req("R7", 1, 1, 64'h3C0);
    req("R4", 0, 1, 64'h3C0);
    idle("R2");

    // R9: memory enable only, then all clear
    writeCfg(4'h2);
    req("R9", 0, 1, 64'h1800);
    req("R9", 1, 1, 64'h3C0);
    req("R9", 1, 0, 64'hB0000);
    writeCfg(4'h0);
    req("R9", 1, 0, 64'hB0000);
    req("R9", 0, 1, 64'h1800);
    idle("R2");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule